// File: doc/BRIEF.md
# Phase-Selection QPSK Sample Modulator

This block turns a serial bit stream into a stream of 8-bit carrier samples for a parallel DAC. It collects the accepted bits in pairs. Each pair forms a two-bit symbol, and that symbol picks one of four quarter-period rotations of a fixed eight-sample carrier waveform. The block uses no multiplier and no quadrature mixing. The carrier is produced by rotating a table index.

A free-running three-bit sample index steps once per clock. One carrier period therefore lasts eight clocks, and one symbol interval is one carrier period. A completed symbol waits in a one-entry holding register until the current period ends. It is then moved into the phase register, which does not change for the whole next period. As a result, a constant symbol stream gives a strictly periodic sample sequence, and a pseudo-random stream changes the phase from one period to the next.

The carrier table T is, by index 0 to 7: 0x00, 0x5A, 0x7F, 0xBF, 0xFF, 0xBF, 0x7F, 0x5A.

Top module: `qpsk_phase_mod`

## Requirements
- R1: While rst_ni is low, sample_valid_o is 0, phase_o is 0 and sample_o is 0x00. After rst_ni rises, sample_o stays 0x00 for as long as sample_valid_o is 0. The sample index restarts at position 0 in the first cycle after release.
- R2: A bit is accepted only on a clock edge where bit_valid_i is 1. The first accepted bit of a pair becomes symbol bit 1 (MSB) and the second becomes symbol bit 0.
- R3: phase_o changes only on a period-boundary edge. The first boundary edge is the eighth rising edge after release, and every eighth edge after that is also a boundary. The loaded value comes from a pair completed on an earlier edge. A pair completed on the boundary edge itself is loaded at the following boundary.
- R4: While sample_valid_o is 1, sample_o equals T[(k + 2·p) mod 8]. Here p is phase_o, and k is the position within the period: 0 in the first cycle after a boundary or after release, counting up to 7.
- R5: sample_valid_o rises in the first cycle of the period that follows the first phase load. It then stays 1 until reset.
- R6: A repeated symbol gives the same eight samples in every period. An alternating input that starts with 1 settles on phase 2.
- R7: If two pairs complete within one period, the later pair is the one loaded at the next boundary.
- R8: Changes on bit_i while bit_valid_i is 0 affect neither the pairing nor the phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bit_i | input | 1 | Serial data bit |
| bit_valid_i | input | 1 | Qualifies bit_i on this edge |
| sample_o | output | 8 | Carrier sample for the DAC |
| sample_valid_o | output | 1 | High once the first symbol is on air |
| phase_o | output | 2 | Current phase selector |

## Verification
Two functions can act on the same clock edge: completing a new bit pair and loading the phase register at a period boundary. The bench provokes this by placing the second bit of a pair in the last slot of a period. It then checks two things: the next period still shows the old phase with its full eight-sample rotation, and the period after that shows the new symbol. A related collision puts two complete pairs inside one period, and the bench checks that only the later pair appears after the boundary.

// File: rtl/qpsk_mod_pkg.sv
package qpsk_mod_pkg;
  localparam int CYCLE_LEN = 8;
  localparam int SYM_W     = 2;
  localparam int SAMPLE_W  = 8;
  localparam int IDX_W     = $clog2(CYCLE_LEN);
  localparam int QUARTER   = CYCLE_LEN / 4;

  typedef logic [SYM_W-1:0]    sym_t;
  typedef logic [IDX_W-1:0]    idx_t;
  typedef logic [SAMPLE_W-1:0] smp_t;

  function automatic smp_t carrier_lut(idx_t i);
    smp_t s;
    case (i)
      3'd0:    s = 8'h00;
      3'd1:    s = 8'h5A;
      3'd2:    s = 8'h7F;
      3'd3:    s = 8'hBF;
      3'd4:    s = 8'hFF;
      3'd5:    s = 8'hBF;
      3'd6:    s = 8'h7F;
      default: s = 8'h5A;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/qpsk_bit_pair.sv
module qpsk_bit_pair
  import qpsk_mod_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_i,
  input  logic bit_valid_i,
  output logic pair_vld_o,
  output sym_t pair_o
);
  logic half_q;
  logic first_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_q  <= 1'b0;
      first_q <= 1'b0;
    end else if (bit_valid_i) begin
      half_q <= ~half_q;
      if (!half_q) first_q <= bit_i;
    end
  end

  // pair completes on the second accepted bit
  assign pair_vld_o = bit_valid_i & half_q;
  assign pair_o     = {first_q, bit_i};

  p_ignore_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_valid_i |=> ($stable(half_q) && $stable(first_q)));
endmodule

// File: rtl/qpsk_phase_ctl.sv
module qpsk_phase_ctl
  import qpsk_mod_pkg::*;
#(
  parameter int LEN = CYCLE_LEN
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pair_vld_i,
  input  sym_t pair_i,
  output idx_t cnt_o,
  output sym_t phase_o,
  output logic loaded_o
);
  localparam idx_t LAST = idx_t'(LEN - 1);

  idx_t cnt_q;
  sym_t phase_q;
  sym_t pend_sym_q;
  logic pend_q;
  logic loaded_q;
  logic boundary;

  assign boundary = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      phase_q    <= '0;
      pend_sym_q <= '0;
      pend_q     <= 1'b0;
      loaded_q   <= 1'b0;
    end else begin
      cnt_q <= cnt_q + idx_t'(1);
      // new pair wins over boundary consumption; load uses old holding value
      if (pair_vld_i) begin
        pend_q     <= 1'b1;
        pend_sym_q <= pair_i;
      end else if (boundary) begin
        pend_q <= 1'b0;
      end
      if (boundary && pend_q) begin
        phase_q  <= pend_sym_q;
        loaded_q <= 1'b1;
      end
    end
  end

  assign cnt_o    = cnt_q;
  assign phase_o  = phase_q;
  assign loaded_o = loaded_q;

  p_load_at_boundary_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(phase_q) |-> ($past(cnt_q) == LAST));

  p_load_needs_pending_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(phase_q) |-> $past(pend_q));

  p_pair_held_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pair_vld_i |=> (pend_q && pend_sym_q == $past(pair_i)));

  p_valid_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loaded_q |=> loaded_q);

  p_valid_at_start_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(loaded_q) |-> (cnt_q == '0));
endmodule

// File: rtl/qpsk_sample_lut.sv
module qpsk_sample_lut
  import qpsk_mod_pkg::*;
(
  input  idx_t cnt_i,
  input  sym_t phase_i,
  input  logic en_i,
  output smp_t sample_o
);
  idx_t idx;

  assign idx      = cnt_i + idx_t'(int'(phase_i) * QUARTER);
  assign sample_o = en_i ? carrier_lut(idx) : '0;
endmodule

// File: rtl/qpsk_phase_mod.sv
module qpsk_phase_mod
  import qpsk_mod_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bit_i,
  input  logic                bit_valid_i,
  output logic [SAMPLE_W-1:0] sample_o,
  output logic                sample_valid_o,
  output logic [SYM_W-1:0]    phase_o
);
  logic pair_vld;
  sym_t pair;
  idx_t cnt;
  sym_t phase;
  logic loaded;

  qpsk_bit_pair u_pair (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bit_i       (bit_i),
    .bit_valid_i (bit_valid_i),
    .pair_vld_o  (pair_vld),
    .pair_o      (pair)
  );

  qpsk_phase_ctl #(.LEN(CYCLE_LEN)) u_ctl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pair_vld_i (pair_vld),
    .pair_i     (pair),
    .cnt_o      (cnt),
    .phase_o    (phase),
    .loaded_o   (loaded)
  );

  qpsk_sample_lut u_lut (
    .cnt_i    (cnt),
    .phase_i  (phase),
    .en_i     (loaded),
    .sample_o (sample_o)
  );

  assign sample_valid_o = loaded;
  assign phase_o        = phase;

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_valid_o |-> (phase_o == '0));
endmodule

// File: tb/qpsk_phase_mod_tb.sv
module qpsk_phase_mod_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       bit_d;
  logic       bv;
  logic [7:0] smp;
  logic       sv;
  logic [1:0] ph;

  int checks = 0;
  int errors = 0;
  logic [1:0] exp_p = 2'b00;
  logic       exp_v = 1'b0;

  logic [7:0] tbl [8] = '{8'h00, 8'h5A, 8'h7F, 8'hBF, 8'hFF, 8'hBF, 8'h7F, 8'h5A};

  localparam int NV = 10;
  localparam logic [1:0] VEC [NV] = '{2'b10, 2'b10, 2'b10, 2'b00, 2'b01,
                                      2'b11, 2'b10, 2'b01, 2'b00, 2'b11};

  always #5 clk = ~clk;

  qpsk_phase_mod u_dut (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .bit_i          (bit_d),
    .bit_valid_i    (bv),
    .sample_o       (smp),
    .sample_valid_o (sv),
    .phase_o        (ph)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // called at a negedge: check outputs for position k, then drive inputs for this slot
  task automatic slot(input int k, input logic v, input logic b, input string req);
    chk({req, " valid"}, 32'(sv), 32'(exp_v));
    chk({req, " phase"}, 32'(ph), 32'(exp_p));
    chk({req, " sample"}, 32'(smp), exp_v ? 32'(tbl[(k + 2 * int'(exp_p)) % 8]) : 32'h0);
    bv    = v;
    bit_d = b;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic period(input int f1, input logic [1:0] y1,
                        input int f2, input logic [1:0] y2, input string req);
    for (int k = 0; k < 8; k++) begin
      if (f1 >= 0 && k == f1)          slot(k, 1'b1, y1[1], req);
      else if (f1 >= 0 && k == f1 + 1) slot(k, 1'b1, y1[0], req);
      else if (f2 >= 0 && k == f2)     slot(k, 1'b1, y2[1], req);
      else if (f2 >= 0 && k == f2 + 1) slot(k, 1'b1, y2[0], req);
      else                             slot(k, 1'b0, k[0], req); // R8 noise on bit_i
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bv = 1'b0; bit_d = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R1 reset valid", 32'(sv), 32'h0);
    chk("R1 reset phase", 32'(ph), 32'h0);
    chk("R1 reset sample", 32'(smp), 32'h0);
    rst_n = 1'b1;

    // vector walk: symbol driven in slots 0/1, shown in the following period (R2 R4 R5 R6)
    for (int i = 0; i < NV; i++) begin
      period(0, VEC[i], -1, 2'b00, (i == 0) ? "R1 idle" : "R4 walk");
      exp_p = VEC[i];
      exp_v = 1'b1;
    end
    // R6: repeated symbol after alternating 1010 stream, plus R8 no-valid periods
    period(-1, 2'b00, -1, 2'b00, "R8 idle");
    period(-1, 2'b00, -1, 2'b00, "R6 hold");

    // R3: pair completing at the boundary edge waits one more period
    period(6, 2'b01, -1, 2'b00, "R3 late");
    period(-1, 2'b00, -1, 2'b00, "R3 late wait");
    exp_p = 2'b01;
    // R3: pair completing one edge before the boundary is loaded at it
    period(5, 2'b11, -1, 2'b00, "R3 late load");
    exp_p = 2'b11;
    // R7: later of two pairs in one period wins
    period(0, 2'b00, 3, 2'b10, "R7 first");
    exp_p = 2'b10;
    period(-1, 2'b00, -1, 2'b00, "R7 second");

    // R1: mid-run reset, then restart aligned at position 0
    rst_n = 1'b0;
    #1;
    chk("R1 midreset valid", 32'(sv), 32'h0);
    chk("R1 midreset phase", 32'(ph), 32'h0);
    chk("R1 midreset sample", 32'(smp), 32'h0);
    exp_p = 2'b00;
    exp_v = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    period(0, 2'b01, -1, 2'b00, "R1 restart");
    exp_p = 2'b01;
    exp_v = 1'b1;
    period(0, 2'b10, -1, 2'b00, "R2 msb");
    exp_p = 2'b10;
    period(-1, 2'b00, -1, 2'b00, "R2 msb show");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule